// File: doc/BRIEF.md
# Address Remap Control Register Block

This block holds the software-visible controls of a graphics address remapping unit. It stores a cache-control byte, a command halfword and the physical base of the translation page directory. Each of these is driven continuously onto an output port so the translation engine can use it. Software reaches the block over a simple synchronous register bus that carries byte, halfword and word accesses inside a 4 KB window.

Two self-clearing flush registers let software invalidate translation state. One drops posted translation entries and the other drops cached directory entries. Writing 1 to a flush register sets a busy bit, and that bit drives a request line toward the translation engine. The bit stays set, and reads back as 1, until the engine returns a done pulse. Software therefore starts a flush by writing 1 and then polls the register until it reads 0.

Top module: `gart_ctl_regs`

## Requirements
- R1: After reset every stored register is zero, both flush request outputs are low and `bus_rvalid` is low.
- R2: The cache-control byte sits at offset 0x02. It is writable, reads back as written and drives `cache_ctrl_o`.
- R3: The command halfword sits at offset 0x00. All 16 bits are writable, read back as written and drive `cmd_o`.
- R4: The page-directory base word sits at offset 0x04. Bits 11:0 always hold zero, whatever is written, and the word drives `dir_base_o`.
- R5: Size codes are 0 for byte, 1 for halfword and 2 for word. A write changes only the low 1, 2 or 4 bytes of the addressed register. A read returns only those low bytes, with the bits above them zero.
- R6: Size code 3 is reserved. A write with it changes nothing, and a read with it returns zero.
- R7: Read data appears on `bus_rdata` with `bus_rvalid` high in the cycle after `bus_rd` is sampled. `bus_rvalid` is low in every other cycle.
- R8: Offsets other than 0x00, 0x02, 0x04, 0x0C and 0x14 read as zero. Writes to them change nothing.
- R9: A write with bit 0 set to the post-flush register at offset 0x14 sets its busy bit at the next clock. `post_flush_req` is high while that bit is set, and bit 0 of a read returns it.
- R10: The directory-flush register at offset 0x0C behaves the same way, using `dir_flush_req` and its own busy bit.
- R11: A done pulse clears the matching busy bit at the next clock. A done pulse that arrives while the flush is idle has no effect.
- R12: Writes to a flush register while it is busy are ignored, so a write of 1 does not re-arm it. A write with bit 0 clear never starts a flush and never clears one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte offset in the register window |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | 32 | Write data, right-justified |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| post_flush_req | output | 1 | Posted-entry flush request |
| post_flush_done | input | 1 | Posted-entry flush completion |
| dir_flush_req | output | 1 | Directory flush request |
| dir_flush_done | input | 1 | Directory flush completion |
| cache_ctrl_o | output | 8 | Cache-control byte |
| cmd_o | output | 16 | Command halfword |
| dir_base_o | output | 32 | Page-directory base |

## Verification
Each result has a fixed due time. A write takes effect on the register outputs and the request lines at the first clock edge after it is presented. A read is answered with `bus_rvalid` one edge later, and a done pulse clears its busy bit one edge after it is sampled. The bench drives every input on the falling edge and checks outputs on the next falling edge, which is the point where that single register stage has settled. Each read pushes its expected word into a queue, and a monitor pops one entry for every cycle in which `bus_rvalid` is high. A response that arrives late or is missing therefore leaves the queue out of step and fails the comparison.

// File: rtl/gart_ctl_pkg.sv
package gart_ctl_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  localparam int OFS_CMD       = 'h00;
  localparam int OFS_CACHE     = 'h02;
  localparam int OFS_DIRBASE   = 'h04;
  localparam int OFS_DIR_FLUSH = 'h0C;
  localparam int OFS_PST_FLUSH = 'h14;

  function automatic logic [31:0] lane_mask(input logic [1:0] sz);
    case (acc_size_e'(sz))
      SZ_BYTE: lane_mask = 32'h0000_00FF;
      SZ_HALF: lane_mask = 32'h0000_FFFF;
      SZ_WORD: lane_mask = 32'hFFFF_FFFF;
      default: lane_mask = 32'h0000_0000;
    endcase
  endfunction

  function automatic logic [31:0] merge_lanes(input logic [31:0] old_v,
                                              input logic [31:0] new_v,
                                              input logic [1:0]  sz);
    logic [31:0] m;
    m = lane_mask(sz);
    merge_lanes = (old_v & ~m) | (new_v & m);
  endfunction

endpackage

// File: rtl/gart_flush_unit.sv
module gart_flush_unit #(
  parameter int ADDR_W = 12,
  parameter int OFFSET = 'h14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              wbit0,
  input  logic              done,
  output logic              busy
);
  import gart_ctl_pkg::*;

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(OFFSET);

  logic hit;
  logic start;

  assign hit   = wr && (addr == HIT_ADDR) && (acc_size_e'(size) != SZ_RSVD);
  assign start = hit && wbit0 && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
    end else if (busy) begin
      if (done) busy <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
    end
  end

  // R9
  start_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && hit && wbit0) |=> busy);

  // R11
  done_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && done) |=> !busy);

  // R12
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(hit && wbit0)) |=> !busy);

endmodule

// File: rtl/gart_reg_store.sv
module gart_reg_store #(
  parameter int ADDR_W    = 12,
  parameter int CACHE_W   = 8,
  parameter int CMD_W     = 16,
  parameter int DIR_ALIGN = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [1:0]         size,
  input  logic [31:0]        wdata,
  output logic [CACHE_W-1:0] cache_q,
  output logic [CMD_W-1:0]   cmd_q,
  output logic [31:0]        dir_q
);
  import gart_ctl_pkg::*;

  localparam logic [31:0]       DIR_KEEP  = ~((32'd1 << DIR_ALIGN) - 32'd1);
  localparam logic [ADDR_W-1:0] A_CACHE   = ADDR_W'(OFS_CACHE);
  localparam logic [ADDR_W-1:0] A_CMD     = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_DIR     = ADDR_W'(OFS_DIRBASE);

  logic [31:0] cache_m, cmd_m, dir_m;

  always_comb begin
    cache_m = merge_lanes(32'(cache_q), wdata, size);
    cmd_m   = merge_lanes(32'(cmd_q), wdata, size);
    dir_m   = merge_lanes(dir_q, wdata, size) & DIR_KEEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cache_q <= '0;
      cmd_q   <= '0;
      dir_q   <= '0;
    end else if (wr) begin
      if (addr == A_CACHE) cache_q <= cache_m[CACHE_W-1:0];
      if (addr == A_CMD)   cmd_q   <= cmd_m[CMD_W-1:0];
      if (addr == A_DIR)   dir_q   <= dir_m;
    end
  end

  // R4
  dir_align_chk: assert property (@(posedge clk) disable iff (rst)
    (dir_q & ~DIR_KEEP) == 32'd0);

  // R6
  rsvd_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && size == 2'd3) |=> ($stable(cmd_q) && $stable(cache_q) && $stable(dir_q)));

endmodule

// File: rtl/gart_read_port.sv
module gart_read_port #(
  parameter int ADDR_W  = 12,
  parameter int CACHE_W = 8,
  parameter int CMD_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [1:0]         size,
  input  logic [CACHE_W-1:0] cache_q,
  input  logic [CMD_W-1:0]   cmd_q,
  input  logic [31:0]        dir_q,
  input  logic               post_busy,
  input  logic               dir_busy,
  output logic [31:0]        rdata,
  output logic               rvalid
);
  import gart_ctl_pkg::*;

  logic [31:0] sel;

  always_comb begin
    case (int'(addr))
      OFS_CMD:       sel = 32'(cmd_q);
      OFS_CACHE:     sel = 32'(cache_q);
      OFS_DIRBASE:   sel = dir_q;
      OFS_DIR_FLUSH: sel = {31'd0, dir_busy};
      OFS_PST_FLUSH: sel = {31'd0, post_busy};
      default:       sel = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= sel & lane_mask(size);
    end
  end

  // R7
  rvalid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    rd |=> rvalid);

  // R7
  rvalid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> !rvalid);

endmodule

// File: rtl/gart_ctl_regs.sv
module gart_ctl_regs #(
  parameter int ADDR_W    = 12,
  parameter int CACHE_W   = 8,
  parameter int CMD_W     = 16,
  parameter int DIR_ALIGN = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [1:0]         bus_size,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_rvalid,
  output logic               post_flush_req,
  input  logic               post_flush_done,
  output logic               dir_flush_req,
  input  logic               dir_flush_done,
  output logic [CACHE_W-1:0] cache_ctrl_o,
  output logic [CMD_W-1:0]   cmd_o,
  output logic [31:0]        dir_base_o
);
  import gart_ctl_pkg::*;

  localparam int NFLUSH = 2;
  localparam int FLUSH_OFS [NFLUSH] = '{OFS_PST_FLUSH, OFS_DIR_FLUSH};

  logic [NFLUSH-1:0] busy;
  logic [NFLUSH-1:0] done_v;

  assign done_v = {dir_flush_done, post_flush_done};

  gart_reg_store #(
    .ADDR_W(ADDR_W), .CACHE_W(CACHE_W), .CMD_W(CMD_W), .DIR_ALIGN(DIR_ALIGN)
  ) u_store (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .size(bus_size),
    .wdata(bus_wdata), .cache_q(cache_ctrl_o), .cmd_q(cmd_o), .dir_q(dir_base_o)
  );

  for (genvar g = 0; g < NFLUSH; g++) begin : g_flush
    gart_flush_unit #(.ADDR_W(ADDR_W), .OFFSET(FLUSH_OFS[g])) u_flush (
      .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .size(bus_size),
      .wbit0(bus_wdata[0]), .done(done_v[g]), .busy(busy[g])
    );
  end

  assign post_flush_req = busy[0];
  assign dir_flush_req  = busy[1];

  gart_read_port #(.ADDR_W(ADDR_W), .CACHE_W(CACHE_W), .CMD_W(CMD_W)) u_read (
    .clk(clk), .rst(rst), .rd(bus_rd), .addr(bus_addr), .size(bus_size),
    .cache_q(cache_ctrl_o), .cmd_q(cmd_o), .dir_q(dir_base_o),
    .post_busy(busy[0]), .dir_busy(busy[1]),
    .rdata(bus_rdata), .rvalid(bus_rvalid)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!post_flush_req && !dir_flush_req && !bus_rvalid && cmd_o == '0));

endmodule

// File: tb/gart_ctl_regs_bench.sv
module gart_ctl_regs_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        post_flush_req, dir_flush_req;
  logic        post_flush_done = 1'b0, dir_flush_done = 1'b0;
  logic [7:0]  cache_ctrl_o;
  logic [15:0] cmd_o;
  logic [31:0] dir_base_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  gart_ctl_regs u_gart_ctl_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .post_flush_req(post_flush_req),
    .post_flush_done(post_flush_done), .dir_flush_req(dir_flush_req),
    .dir_flush_done(dir_flush_done), .cache_ctrl_o(cache_ctrl_o), .cmd_o(cmd_o),
    .dir_base_o(dir_base_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [1:0] s, input logic [31:0] e,
                    input string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_rd = 1'b1; bus_addr = a; bus_size = s;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_done(input bit dir_sel);
    @(negedge clk);
    if (dir_sel) dir_flush_done = 1'b1; else post_flush_done = 1'b1;
    @(negedge clk);
    dir_flush_done = 1'b0; post_flush_done = 1'b0;
  endtask

  // Monitor: every valid response is compared against the oldest expectation
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 unexpected response actual=%h expected=none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 cache", 32'(cache_ctrl_o), 32'h0);
    check("R1 cmd", 32'(cmd_o), 32'h0);
    check("R1 dir", dir_base_o, 32'h0);
    check("R1 reqs", {30'd0, post_flush_req, dir_flush_req}, 32'h0);
    check("R1 rvalid", 32'(bus_rvalid), 32'h0);
    rd(12'h004, 2'd2, 32'h0, "R1 dir read");

    // R2 cache byte
    wr(12'h002, 2'd0, 32'h0000_000A);
    check("R2 cache out", 32'(cache_ctrl_o), 32'h0A);
    rd(12'h002, 2'd0, 32'h0A, "R2 cache read");

    // R3 command halfword
    wr(12'h000, 2'd1, 32'h0000_BEEF);
    check("R3 cmd out", 32'(cmd_o), 32'hBEEF);
    rd(12'h000, 2'd1, 32'hBEEF, "R3 cmd read");
    rd(12'h000, 2'd0, 32'hEF, "R5 byte read of cmd");

    // R4 / R5 directory base
    wr(12'h004, 2'd2, 32'h1234_5678);
    check("R4 dir out", dir_base_o, 32'h1234_5000);
    wr(12'h004, 2'd0, 32'h0000_00FF);
    check("R5 byte write dir", dir_base_o, 32'h1234_5000);
    wr(12'h004, 2'd1, 32'hFFFF_ABCD);
    check("R5 half write dir", dir_base_o, 32'h1234_A000);
    rd(12'h004, 2'd2, 32'h1234_A000, "R4 dir read");
    rd(12'h004, 2'd1, 32'h0000_A000, "R5 half read dir");

    // R6 reserved size
    wr(12'h000, 2'd3, 32'h0000_1111);
    check("R6 rsvd write", 32'(cmd_o), 32'hBEEF);
    rd(12'h000, 2'd3, 32'h0, "R6 rsvd read");

    // R8 unmapped offsets
    wr(12'h008, 2'd2, 32'hFFFF_FFFF);
    rd(12'h008, 2'd2, 32'h0, "R8 unmapped 0x08");
    rd(12'h800, 2'd2, 32'h0, "R8 unmapped 0x800");
    check("R8 regs untouched", dir_base_o, 32'h1234_A000);

    // R12 write of 0 does not start
    wr(12'h014, 2'd0, 32'h0);
    check("R12 zero write idle", 32'(post_flush_req), 32'h0);

    // R9 post flush start
    wr(12'h014, 2'd0, 32'h1);
    check("R9 post req", 32'(post_flush_req), 32'h1);
    check("R9 dir req independent", 32'(dir_flush_req), 32'h0);
    rd(12'h014, 2'd0, 32'h1, "R9 post busy read");

    // R12 writes while busy ignored
    wr(12'h014, 2'd0, 32'h0);
    check("R12 zero write busy", 32'(post_flush_req), 32'h1);
    wr(12'h014, 2'd0, 32'h1);

    // R11 done clears, no re-arm
    pulse_done(1'b0);
    check("R11 post cleared", 32'(post_flush_req), 32'h0);
    rd(12'h014, 2'd0, 32'h0, "R11 post read idle");
    pulse_done(1'b0);
    check("R11 done while idle", 32'(post_flush_req), 32'h0);

    // R10 directory flush
    wr(12'h00C, 2'd2, 32'h1);
    check("R10 dir req", 32'(dir_flush_req), 32'h1);
    check("R10 post req independent", 32'(post_flush_req), 32'h0);
    rd(12'h00C, 2'd2, 32'h1, "R10 dir busy read");
    pulse_done(1'b0);
    check("R11 wrong done ignored", 32'(dir_flush_req), 32'h1);
    pulse_done(1'b1);
    check("R11 dir cleared", 32'(dir_flush_req), 32'h0);
    rd(12'h00C, 2'd2, 32'h0, "R10 dir read idle");

    repeat (3) @(negedge clk);
    check("R7 responses drained", 32'(exp_q.size()), 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule